// File: doc/BRIEF.md
# Frequency-Locking Delay Tap Controller

This block steers the tap index of a ring oscillator built from a tapped delay line. Selecting a longer tap lengthens the oscillator period. The goal is an oscillator frequency of M/D times the reference clock. The controller never observes phase. Instead it counts oscillator rising edges over a measurement window made of reference cycles, and it compares that count with the ideal count for the programmed ratio.

At the end of each window the controller issues one verdict. If the oscillator ran fast, the tap index grows by one. If it ran slow, the index shrinks by one. If the count matched, the index holds. The index is never moved by more than one step, so a verdict made wrong by jitter costs at most one tap, and later windows correct it.

The oscillator edge count is kept in the oscillator's own domain as a Gray-coded counter. A two-flop synchroniser brings it into the reference domain, where consecutive snapshots are subtracted to give the count for one window. A lock indicator rises once the loop has settled, meaning it has either matched the target or reversed its correction for a programmed number of windows in a row.

Top module: `freq_tap_lock`

## Requirements
- R1: While `rst` is high at a reference clock edge, the tap index becomes mid-range, 2^(TAP_W-1) (32 with defaults). `locked` goes low, and the window restarts from its first cycle once `rst` falls.
- R2: A window lasts max(`div_d`,1) x 2^K reference cycles, so a `div_d` of zero acts as one. Exactly one verdict is made per window, and the tap index moves at the clock edge that ends the window's last cycle.
- R3: If the window's oscillator edge count is greater than `mult_m` x 2^K, the tap index increases by one, which gives a longer delay and a lower frequency.
- R4: If the window's edge count is less than `mult_m` x 2^K, the tap index decreases by one.
- R5: If the window's edge count equals `mult_m` x 2^K, the tap index is unchanged.
- R6: The tap index changes only at a window end, and by exactly one step when it does.
- R7: The tap index saturates: a decrease at 0 leaves it at 0, and an increase at 2^TAP_W-1 (63) leaves it there. It never wraps.
- R8: A window is settled if its verdict is hold, or if it reverses the previous window's increase or decrease. The count of consecutive settled windows saturates at 2^LOCK_W-1 and is cleared by any unsettled window. `locked` is high while this count is nonzero and at least `lock_need`.
- R9: Oscillator rising edges reach the window count through the Gray-coded counter and two synchroniser flops. An edge that arrives too late for one window is counted in the next, so none is lost or counted twice, provided one window sees fewer than 2^CNT_W edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high; also sampled by the oscillator-domain counter |
| osc_clk | input | 1 | Ring oscillator output whose rising edges are counted |
| mult_m | input | M_W | Frequency multiplier M |
| div_d | input | D_W | Frequency divider D; zero is treated as one |
| lock_need | input | LOCK_W | Number of consecutive settled windows required for lock |
| tap_sel | output | TAP_W | Tap index of the delay line; larger means a longer period |
| locked | output | 1 | Loop has settled |

## Verification
A single window end can carry three events at once: a tap step that hits a saturation limit, an update of the settled-window run that raises or drops `locked`, and the snapshot that starts the next window's count. The bench provokes all three together. It drives the index to 63 and to 0 with steady fast and slow edge streams. It also feeds edge patterns that alternate between one edge above and one edge below the target while the index sits on 0, so the lock run builds while the tap is pinned. A behavioural model in the bench keeps its own edge history with a three-cycle visibility delay, and it compares tap index and lock flag with the design after every clock edge.

// File: rtl/ftl_pkg.sv
`timescale 1ns/1ps
package ftl_pkg;

  // Result of one measurement window.
  typedef enum logic [1:0] {
    VD_HOLD    = 2'd0,
    VD_LONGER  = 2'd1,
    VD_SHORTER = 2'd2
  } verdict_t;

  // Too many edges means the oscillator is fast: lengthen the delay.
  function automatic verdict_t judge(input logic [31:0] seen, input logic [31:0] want);
    if (seen > want) return VD_LONGER;
    if (seen < want) return VD_SHORTER;
    return VD_HOLD;
  endfunction

endpackage

// File: rtl/ftl_edge_count.sv
`timescale 1ns/1ps
module ftl_edge_count #(
  parameter int CNT_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             osc_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] seen_bin
);

  function automatic logic [CNT_W-1:0] to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] from_gray(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Oscillator domain: binary and Gray copies of the edge count.
  logic [CNT_W-1:0] bin_o, gray_o;
  always_ff @(posedge osc_clk) begin
    if (rst) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else begin
      bin_o  <= bin_o + 1'b1;
      gray_o <= to_gray(bin_o + 1'b1);
    end
  end

  // Reference domain: synchroniser chain on the Gray value.
  logic [CNT_W-1:0] sync_q [SYNC_N];
  always_ff @(posedge clk) begin
    sync_q[0] <= gray_o;
    for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
  end

  assign seen_bin = from_gray(sync_q[SYNC_N-1]);

endmodule

// File: rtl/ftl_window.sv
`timescale 1ns/1ps
module ftl_window #(
  parameter int D_W = 4,
  parameter int K   = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [D_W-1:0] div_d,
  output logic           win_end
);

  localparam int WIN_W = D_W + K;

  // Index of the final cycle of a window; a zero divider counts as one.
  function automatic logic [WIN_W-1:0] last_index(input logic [D_W-1:0] d);
    logic [WIN_W-1:0] span;
    span = (d == '0) ? WIN_W'(1) << K : WIN_W'(d) << K;
    return span - 1'b1;
  endfunction

  logic [WIN_W-1:0] win_q;

  // ">=" lets a divider lowered mid-window end the window at once.
  assign win_end = (win_q >= last_index(div_d));

  always_ff @(posedge clk) begin
    if (rst)          win_q <= '0;
    else if (win_end) win_q <= '0;
    else              win_q <= win_q + 1'b1;
  end

endmodule

// File: rtl/ftl_stepper.sv
`timescale 1ns/1ps
module ftl_stepper import ftl_pkg::*; #(
  parameter int TAP_W  = 6,
  parameter int CNT_W  = 10,
  parameter int M_W    = 4,
  parameter int K      = 3,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_end,
  input  logic [CNT_W-1:0]  seen_bin,
  input  logic [M_W-1:0]    mult_m,
  input  logic [LOCK_W-1:0] lock_need,
  output logic [TAP_W-1:0]  tap_sel,
  output logic              locked,
  output verdict_t          verdict,
  output logic              settled
);

  localparam logic [TAP_W-1:0]  TAP_MID = TAP_W'(1) << (TAP_W - 1);
  localparam logic [TAP_W-1:0]  TAP_TOP = '1;
  localparam logic [LOCK_W-1:0] RUN_TOP = '1;

  function automatic logic [TAP_W-1:0] next_tap(input logic [TAP_W-1:0] cur, input verdict_t v);
    case (v)
      VD_LONGER:  return (cur == TAP_TOP) ? cur : cur + 1'b1;
      VD_SHORTER: return (cur == '0) ? cur : cur - 1'b1;
      default:    return cur;
    endcase
  endfunction

  function automatic logic is_settled(input verdict_t v, input verdict_t prev);
    return (v == VD_HOLD) ||
           (v == VD_LONGER  && prev == VD_SHORTER) ||
           (v == VD_SHORTER && prev == VD_LONGER);
  endfunction

  logic [CNT_W-1:0]  base_q, window_count, target;
  logic [LOCK_W-1:0] run_q;
  verdict_t          prev_q;

  assign window_count = seen_bin - base_q;
  assign target       = CNT_W'(mult_m) << K;
  assign verdict      = judge(32'(window_count), 32'(target));
  assign settled      = is_settled(verdict, prev_q);
  assign locked       = (run_q != '0) && (run_q >= lock_need);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_sel <= TAP_MID;
      base_q  <= seen_bin;
      prev_q  <= VD_HOLD;
      run_q   <= '0;
    end else if (win_end) begin
      tap_sel <= next_tap(tap_sel, verdict);
      base_q  <= seen_bin;
      prev_q  <= verdict;
      run_q   <= !settled ? '0 : (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
    end
  end

endmodule

// File: rtl/freq_tap_lock.sv
`timescale 1ns/1ps
module freq_tap_lock import ftl_pkg::*; #(
  parameter int TAP_W  = 6,
  parameter int M_W    = 4,
  parameter int D_W    = 4,
  parameter int K      = 3,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_clk,
  input  logic [M_W-1:0]    mult_m,
  input  logic [D_W-1:0]    div_d,
  input  logic [LOCK_W-1:0] lock_need,
  output logic [TAP_W-1:0]  tap_sel,
  output logic              locked
);

  // Room for up to eight edges per reference cycle, and for the target.
  localparam int HEAD  = (D_W + 3 > M_W + 1) ? D_W + 3 : M_W + 1;
  localparam int CNT_W = HEAD + K;

  logic [CNT_W-1:0] seen_bin;
  logic             win_end;
  verdict_t         verdict;
  logic             settled;

  ftl_edge_count #(.CNT_W(CNT_W), .SYNC_N(2)) count_i (
    .clk(clk), .osc_clk(osc_clk), .rst(rst), .seen_bin(seen_bin)
  );

  ftl_window #(.D_W(D_W), .K(K)) window_i (
    .clk(clk), .rst(rst), .div_d(div_d), .win_end(win_end)
  );

  ftl_stepper #(.TAP_W(TAP_W), .CNT_W(CNT_W), .M_W(M_W), .K(K), .LOCK_W(LOCK_W)) step_i (
    .clk(clk), .rst(rst), .win_end(win_end), .seen_bin(seen_bin),
    .mult_m(mult_m), .lock_need(lock_need), .tap_sel(tap_sel),
    .locked(locked), .verdict(verdict), .settled(settled)
  );

endmodule

// File: rtl/freq_tap_lock_chk.sv
`timescale 1ns/1ps
module freq_tap_lock_chk import ftl_pkg::*; #(
  parameter int TAP_W  = 6,
  parameter int LOCK_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [TAP_W-1:0]  tap_sel,
  input logic              locked,
  input logic [LOCK_W-1:0] lock_need,
  input logic              win_end,
  input verdict_t          verdict,
  input logic              settled
);

  localparam logic [TAP_W-1:0] MID_TAP = TAP_W'(1) << (TAP_W - 1);
  localparam logic [TAP_W-1:0] TOP_TAP = '1;

  a_r1_reset_mid: assert property (@(posedge clk)
    rst |=> (tap_sel == MID_TAP && !locked));

  a_r3_longer_step: assert property (@(posedge clk) disable iff (rst)
    (win_end && verdict == VD_LONGER && tap_sel != TOP_TAP) |=> tap_sel == TAP_W'($past(tap_sel) + 1'b1));

  a_r4_shorter_step: assert property (@(posedge clk) disable iff (rst)
    (win_end && verdict == VD_SHORTER && tap_sel != '0) |=> tap_sel == TAP_W'($past(tap_sel) - 1'b1));

  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (win_end && verdict == VD_HOLD) |=> $stable(tap_sel));

  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tap_sel != $past(tap_sel)) |->
      ($past(win_end) && (tap_sel == TAP_W'($past(tap_sel) + 1'b1) ||
                          tap_sel == TAP_W'($past(tap_sel) - 1'b1))));

  a_r7_floor: assert property (@(posedge clk) disable iff (rst)
    (win_end && verdict == VD_SHORTER && tap_sel == '0) |=> tap_sel == '0);

  a_r7_ceiling: assert property (@(posedge clk) disable iff (rst)
    (win_end && verdict == VD_LONGER && tap_sel == TOP_TAP) |=> tap_sel == TOP_TAP);

  a_r8_lock_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked) && $stable(lock_need)) |-> ($past(win_end) && $past(settled)));

endmodule

bind freq_tap_lock freq_tap_lock_chk #(.TAP_W(TAP_W), .LOCK_W(LOCK_W)) chk_i (
  .clk(clk), .rst(rst), .tap_sel(tap_sel), .locked(locked), .lock_need(lock_need),
  .win_end(win_end), .verdict(verdict), .settled(settled)
);

// File: tb/freq_tap_lock_tb_top.sv
`timescale 1ns/1ps
module freq_tap_lock_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_clk = 1'b0;
  logic [3:0] mult_m = 4'd4;
  logic [3:0] div_d = 4'd4;
  logic [3:0] lock_need = 4'd4;
  logic [5:0] tap_sel;
  logic       locked;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int mode = 0;
  int cpulse = 1;
  int npulse = 1;

  // Behavioural model state.
  int e_now = 0, q1 = 0, q2 = 0, q3 = 0;
  int m_tap = 32, m_win = 0, m_base = 0, m_prev = 0, m_run = 0;
  bit m_locked = 0;

  freq_tap_lock dut_i (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .mult_m(mult_m), .div_d(div_d),
    .lock_need(lock_need), .tap_sel(tap_sel), .locked(locked)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pattern(input int n);
    case (mode)
      1:       return 1 + (n % 2);
      2:       return 1 + (n % 2) + ((n % 32) == 0 ? 1 : 0) - ((n % 32) == 16 ? 1 : 0);
      3:       return (n % 2) ? 3 : 0;
      default: return cpulse;
    endcase
  endfunction

  // Oscillator edges land between 4 and 14 ns after each reference edge.
  always @(posedge clk) begin
    #4;
    for (int i = 0; i < npulse; i++) begin
      osc_clk = 1'b1; #0.5;
      osc_clk = 1'b0; #0.5;
    end
  end

  // Edge count for the next cycle is chosen well after the clock edge.
  always @(posedge clk) begin
    #16;
    npulse = pattern(cyc);
  end

  // Reference model, advanced on every reference edge.
  always @(posedge clk) begin
    int cur, last, diff, target, v;
    bit st;
    cur = q3;
    e_now = rst ? 0 : e_now + npulse;
    q3 = q2; q2 = q1; q1 = e_now;
    if (rst) begin
      m_tap = 32; m_win = 0; m_base = cur; m_prev = 0; m_run = 0;
    end else begin
      last = ((div_d == 0) ? 1 : int'(div_d)) * 8 - 1;
      if (m_win >= last) begin
        diff = ((cur - m_base) % 1024 + 1024) % 1024;
        target = int'(mult_m) * 8;
        v = (diff > target) ? 1 : (diff < target) ? 2 : 0;
        if (v == 1 && m_tap < 63) m_tap++;
        if (v == 2 && m_tap > 0) m_tap--;
        st = (v == 0) || (v == 1 && m_prev == 2) || (v == 2 && m_prev == 1);
        m_run = st ? ((m_run < 15) ? m_run + 1 : 15) : 0;
        m_prev = v;
        m_base = cur;
        m_win = 0;
      end else begin
        m_win++;
      end
    end
    m_locked = (m_run != 0) && (m_run >= int'(lock_need));
    cyc++;
  end

  // Per-cycle comparison with the model, half a period after the edge.
  always @(negedge clk) begin
    if (cyc > 2) begin
      chk(int'(tap_sel) == m_tap, "R6 tap vs model", int'(tap_sel), m_tap);
      chk(locked == m_locked, "R8 locked vs model", int'(locked), int'(m_locked));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #12;
  endtask

  task automatic measure_gap(output int g);
    int t, cnt;
    t = int'(tap_sel); cnt = 0;
    while (int'(tap_sel) == t && cnt < 300) begin wait_cyc(1); cnt++; end
    t = int'(tap_sel); cnt = 0;
    while (int'(tap_sel) == t && cnt < 300) begin wait_cyc(1); cnt++; end
    g = cnt;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, t1, g;
    // R1 reset state
    wait_cyc(5);
    chk(tap_sel == 6'd32, "R1 reset tap", int'(tap_sel), 32);
    chk(locked == 1'b0, "R1 reset locked", int'(locked), 0);
    rst = 1'b0;

    // R3 fast oscillator: 64 edges against a target of 32 per window
    mode = 0; cpulse = 2;
    wait_cyc(32 * 5);
    chk(int'(tap_sel) > 32, "R3 tap grew", int'(tap_sel), 33);
    measure_gap(g);
    chk(g == 32, "R2 window length D=4", g, 32);

    // R4 silent oscillator
    cpulse = 0;
    wait_cyc(40);
    t0 = int'(tap_sel);
    wait_cyc(32 * 3);
    t1 = int'(tap_sel);
    chk(t1 == t0 - 3, "R4 tap shrank by one per window", t1, t0 - 3);

    // R5 exact match: 1,2 alternating gives 48 per 32 cycles
    mult_m = 4'd6; mode = 1;
    wait_cyc(32 * 2);
    t0 = int'(tap_sel);
    wait_cyc(32 * 5);
    chk(int'(tap_sel) == t0, "R5 tap held", int'(tap_sel), t0);
    chk(locked == 1'b1, "R8 locked after hold windows", int'(locked), 1);

    // R8 an unsettled window clears the lock
    mode = 0; cpulse = 3;
    wait_cyc(32 * 2 + 4);
    chk(locked == 1'b0, "R8 lock dropped", int'(locked), 0);

    // R7 ceiling: window 8, target 8, 24 edges
    div_d = 4'd1; mult_m = 4'd1;
    wait_cyc(8 * 70);
    chk(tap_sel == 6'd63, "R7 ceiling reached", int'(tap_sel), 63);
    wait_cyc(8 * 3);
    chk(tap_sel == 6'd63, "R7 ceiling no wrap", int'(tap_sel), 63);

    // R2 divider of zero acts as one; then R7 floor
    div_d = 4'd0; cpulse = 0;
    measure_gap(g);
    chk(g == 8, "R2 window length D=0", g, 8);
    wait_cyc(600);
    chk(tap_sel == 6'd0, "R7 floor reached", int'(tap_sel), 0);
    wait_cyc(8 * 3);
    chk(tap_sel == 6'd0, "R7 floor no wrap", int'(tap_sel), 0);

    // R8 alternation lock: window 16, target 24, counts 25/23 alternate
    div_d = 4'd2; mult_m = 4'd3; mode = 2;
    wait_cyc(16 * 12);
    chk(locked == 1'b1, "R8 locked by alternation", int'(locked), 1);
    chk(int'(tap_sel) <= 1, "R8 tap pinned near floor", int'(tap_sel), 1);

    // R9 bursty edges (0,3 per cycle) still sum to the target
    mode = 3;
    wait_cyc(16 * 3);
    t0 = int'(tap_sel);
    wait_cyc(16 * 5);
    chk(int'(tap_sel) == t0, "R9 no edge lost or doubled", int'(tap_sel), t0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule